// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the per-source state of an interrupt distributor: an enable bit, a trigger mode (edge or level), a handling-model bit (one-of-N versus every-CPU), the last seen input level, and a pending bit for each CPU. It sits between the external interrupt lines and register writes on one side, and the priority selector on the other. The selector reads the enable and pending vectors straight from the state registers.

Four things update the state. Rising and falling external lines are one. Word writes carrying byte strobes to the enable, pending and configuration register groups are another. The third is a software-interrupt word that names a source and a group of CPUs through a 2-bit filter. The last is the requesting-CPU index, which selects the CPU for private sources and for the self-relative filters. All state changes on the clock edge that follows the stimulus.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset, sources 0 to 15 are enabled and edge-triggered. Every other source is disabled and level-triggered. All model bits and pending bits are 0.
- R2: External line n drives source n+32. On a rising line, an edge-triggered source becomes pending for every CPU set in its target mask. A line that holds its level, or that falls, sets nothing.
- R3: A rising line on a level-triggered source sets pending only if the source is enabled at that time.
- R4: wrKind 0 (set-enable) enables each source whose bit is 1. If that source is level-triggered and its line is high in the same cycle, it also becomes pending for its target CPUs.
- R5: wrKind 1 (clear-enable) disables each source whose bit is 1. Sources 0 to 15 stay enabled whatever is written, and set-enable writes to them always enable them.
- R6: wrKind 2 (set-pending) makes the source pending for its target mask. For sources below 32, the target is the requesting CPU. wrKind 3 (clear-pending) clears the source's pending bits for all CPUs.
- R7: wrKind 4 (configuration) word k sets source 16k+f from bits [2f+1:2f]. The low bit is the model (1 means 1:N) and the high bit selects edge triggering. Sources below 32 always end up edge-triggered.
- R8: wrKind 5 (software interrupt) takes the source ID from wrData[9:0] and the filter from wrData[25:24]. Filter 0 targets the CPUs listed in wrData[23:16]. Filter 1 targets only the requester, filter 2 targets every CPU except the requester, and filter 3 targets all CPUs. An ID of NUM_SRC or more has no effect.
- R9: When a set and a clear of the same source's pending bit land in the same cycle, the set wins.
- R10: For wrKind 0 to 3, word k bit b addresses source 32k+b. A byte lane whose wrStrb bit is 0 leaves the sources it covers unchanged, and the same applies to configuration writes. Software-interrupt writes ignore the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extLines | input | NUM_SRC-32 | External interrupt input levels |
| tgtMask | input | (NUM_SRC-32)*NUM_CPU | Target CPU mask per external source, source 32+n at [n*NUM_CPU +: NUM_CPU] |
| reqCpu | input | CPU_IDX_W | Index of the CPU making the current write |
| wrEn | input | 1 | Register write valid |
| wrKind | input | 3 | Register group: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 configuration, 5 software interrupt |
| wrWordIdx | input | IDX_W | Word index within the group |
| wrStrb | input | 4 | Byte-lane write strobes |
| wrData | input | 32 | Write data |
| enVec | output | NUM_SRC | Enable bit per source |
| trigVec | output | NUM_SRC | Edge-trigger bit per source |
| modelVec | output | NUM_SRC | 1:N model bit per source |
| pendVec | output | NUM_SRC*NUM_CPU | Pending bits, source s CPU c at s*NUM_CPU+c |

## Verification
The directed cases cover the following situations:
- A line held high after its pending bit was cleared. A design that retriggers on level here would set pending again.
- A rising line on a disabled level source. A careless design would set pending anyway.
- A clear-enable of the always-on sources. A design that fails here would lose software interrupts.
- A rising edge that coincides with a clear-pending. If clear won, the interrupt would be lost.
- Each of the four software-interrupt filters. A misdecode would wake the wrong CPUs.
- A write with partial strobes. A design that ignores lane gating would change neighbouring sources.

Beyond these, random cycles mix every write kind with toggling lines and random target masks, and the whole state is compared to a reference model after every cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int WORD_IDX_W = 8;

  typedef enum logic [2:0] {
    KIND_SET_EN   = 3'd0,
    KIND_CLR_EN   = 3'd1,
    KIND_SET_PEND = 3'd2,
    KIND_CLR_PEND = 3'd3,
    KIND_CONFIG   = 3'd4,
    KIND_SOFT     = 3'd5
  } wrKind_e;

  // Decoded write strobes from the control to the datapath.
  typedef struct packed {
    logic                  setEn;
    logic                  clrEn;
    logic                  setPend;
    logic                  clrPend;
    logic                  cfgWr;
    logic                  softFire;
    logic [WORD_IDX_W-1:0] wordIdx;
    logic [3:0]            lanes;
    logic [31:0]           data;
    logic [9:0]            softId;
  } strobe_t;

endpackage

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int IDX_W     = 2,
  parameter int CPU_IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           wrKind,
  input  logic [IDX_W-1:0]     wrWordIdx,
  input  logic [3:0]           wrStrb,
  input  logic [31:0]          wrData,
  input  logic [CPU_IDX_W-1:0] reqCpu,
  output strobe_t              st,
  output logic [NUM_CPU-1:0]   softCpus
);

  localparam logic [NUM_CPU-1:0] ALL_CPUS = {NUM_CPU{1'b1}};

  logic [NUM_CPU-1:0] selfMask;
  logic [NUM_CPU-1:0] listMask;

  assign selfMask = NUM_CPU'(1) << reqCpu;
  assign listMask = NUM_CPU'(wrData[23:16]);

  always_comb begin
    st         = '0;
    softCpus   = '0;
    st.wordIdx = WORD_IDX_W'(wrWordIdx);
    st.lanes   = wrStrb;
    st.data    = wrData;
    st.softId  = wrData[9:0];
    if (wrEn) begin
      unique case (wrKind_e'(wrKind))
        KIND_SET_EN: begin
          st.setEn = 1'b1;
          if (wrWordIdx == '0) st.data[15:0] = 16'hFFFF;
        end
        KIND_CLR_EN: begin
          st.clrEn = 1'b1;
          if (wrWordIdx == '0) st.data[15:0] = 16'h0000;
        end
        KIND_SET_PEND: st.setPend = 1'b1;
        KIND_CLR_PEND: st.clrPend = 1'b1;
        KIND_CONFIG: begin
          st.cfgWr = 1'b1;
          if (wrWordIdx < IDX_W'(2)) st.data = wrData | 32'hAAAA_AAAA;
        end
        KIND_SOFT: begin
          st.softFire = 1'b1;
          unique case (wrData[25:24])
            2'd0: softCpus = listMask;
            2'd1: softCpus = selfMask;
            2'd2: softCpus = ALL_CPUS & ~selfMask;
            default: softCpus = ALL_CPUS;
          endcase
        end
        default: ;
      endcase
    end
  end

  AST_SOFT_SELF: assert property (@(posedge clk) disable iff (!rstN)
    (st.softFire && wrData[25:24] == 2'd1) |-> $onehot(softCpus))
    else $error("software self filter not one-hot"); // R8
  AST_SOFT_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    (st.softFire && wrData[25:24] == 2'd2) |-> !softCpus[reqCpu])
    else $error("software others filter hit requester"); // R8

endmodule

// File: rtl/irq_pend_state.sv
module irq_pend_state
  import irq_pend_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CPU   = 4,
  parameter int CPU_IDX_W = 2,
  localparam int NUM_EXT  = NUM_SRC - 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      st,
  input  logic [NUM_CPU-1:0]           softCpus,
  input  logic [CPU_IDX_W-1:0]         reqCpu,
  input  logic [NUM_EXT-1:0]           extLines,
  input  logic [NUM_EXT*NUM_CPU-1:0]   tgtMask,
  output logic [NUM_SRC-1:0]           enVec,
  output logic [NUM_SRC-1:0]           trigVec,
  output logic [NUM_SRC-1:0]           modelVec,
  output logic [NUM_SRC*NUM_CPU-1:0]   pendVec
);

  logic [NUM_CPU-1:0] reqOneHot;
  assign reqOneHot = NUM_CPU'(1) << reqCpu;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int   WORD_E = s / 32;
    localparam int   BIT_E  = s % 32;
    localparam int   LANE_E = BIT_E / 8;
    localparam int   WORD_C = s / 16;
    localparam int   FLD    = s % 16;
    localparam int   LANE_C = FLD / 4;
    localparam logic RST_ON = (s < 16);

    logic               enQ, trigQ, modelQ, lvlQ;
    logic [NUM_CPU-1:0] pendQ;
    logic               lineNow;
    logic [NUM_CPU-1:0] tgt;
    logic               hitE, bitE, hitC, softHit, rise, clrAll;
    logic [1:0]         cfgBits;
    logic [NUM_CPU-1:0] setMask;

    if (s >= 32) begin : g_ext
      assign lineNow = extLines[s-32];
      assign tgt     = tgtMask[(s-32)*NUM_CPU +: NUM_CPU];
    end else begin : g_int
      assign lineNow = 1'b0;
      assign tgt     = reqOneHot;
    end

    assign hitE    = (st.wordIdx == WORD_IDX_W'(WORD_E)) && st.lanes[LANE_E];
    assign bitE    = st.data[BIT_E];
    assign hitC    = (st.wordIdx == WORD_IDX_W'(WORD_C)) && st.lanes[LANE_C];
    assign cfgBits = st.data[2*FLD +: 2];
    assign softHit = st.softFire && (st.softId == 10'(s));
    assign rise    = lineNow && !lvlQ;
    assign clrAll  = st.clrPend && hitE && bitE;

    assign setMask =
        ({NUM_CPU{rise && (trigQ || enQ)}} & tgt)
      | ({NUM_CPU{st.setEn && hitE && bitE && lineNow && !trigQ}} & tgt)
      | ({NUM_CPU{st.setPend && hitE && bitE}} & tgt)
      | ({NUM_CPU{softHit}} & softCpus);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ    <= RST_ON;
        trigQ  <= RST_ON;
        modelQ <= 1'b0;
        lvlQ   <= 1'b0;
        pendQ  <= '0;
      end else begin
        if (st.setEn && hitE && bitE)      enQ <= 1'b1;
        else if (st.clrEn && hitE && bitE) enQ <= 1'b0;
        if (st.cfgWr && hitC) begin
          modelQ <= cfgBits[0];
          trigQ  <= cfgBits[1];
        end
        lvlQ  <= lineNow;
        pendQ <= (clrAll ? '0 : pendQ) | setMask;
      end
    end

    assign enVec[s]                       = enQ;
    assign trigVec[s]                     = trigQ;
    assign modelVec[s]                    = modelQ;
    assign pendVec[s*NUM_CPU +: NUM_CPU]  = pendQ;

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (clrAll && setMask != '0) |=> (pendQ != '0))
      else $error("clear overrode set on source %0d", s); // R9
    AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
      (rise && trigQ && tgt != '0) |=> (pendQ != '0))
      else $error("rising edge lost on source %0d", s); // R2
  end

  AST_LOW_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rstN)
    &enVec[15:0])
    else $error("low source disabled"); // R5
  AST_LOW_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    &trigVec[15:0])
    else $error("low source became level-triggered"); // R7

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
#(
  parameter int  NUM_SRC   = 64,
  parameter int  NUM_CPU   = 4,
  localparam int NUM_EXT   = NUM_SRC - 32,
  localparam int IDX_W     = $clog2(NUM_SRC / 16),
  localparam int CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_EXT-1:0]           extLines,
  input  logic [NUM_EXT*NUM_CPU-1:0]   tgtMask,
  input  logic [CPU_IDX_W-1:0]         reqCpu,
  input  logic                         wrEn,
  input  logic [2:0]                   wrKind,
  input  logic [IDX_W-1:0]             wrWordIdx,
  input  logic [3:0]                   wrStrb,
  input  logic [31:0]                  wrData,
  output logic [NUM_SRC-1:0]           enVec,
  output logic [NUM_SRC-1:0]           trigVec,
  output logic [NUM_SRC-1:0]           modelVec,
  output logic [NUM_SRC*NUM_CPU-1:0]   pendVec
);

  strobe_t            st;
  logic [NUM_CPU-1:0] softCpus;

  irq_pend_ctrl #(
    .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .CPU_IDX_W(CPU_IDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind),
    .wrWordIdx(wrWordIdx), .wrStrb(wrStrb), .wrData(wrData),
    .reqCpu(reqCpu), .st(st), .softCpus(softCpus)
  );

  irq_pend_state #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_IDX_W(CPU_IDX_W)
  ) state_i (
    .clk(clk), .rstN(rstN), .st(st), .softCpus(softCpus), .reqCpu(reqCpu),
    .extLines(extLines), .tgtMask(tgtMask), .enVec(enVec),
    .trigVec(trigVec), .modelVec(modelVec), .pendVec(pendVec)
  );

endmodule

// File: tb/irq_pend_tracker_tb.sv
module irq_pend_tracker_tb_top;

  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 4;
  localparam int NUM_EXT = NUM_SRC - 32;
  localparam int PW      = NUM_SRC * NUM_CPU;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic [NUM_EXT-1:0]         extLines = '0;
  logic [NUM_EXT*NUM_CPU-1:0] tgtMask = '0;
  logic [1:0]                 reqCpu = '0;
  logic                       wrEn = 1'b0;
  logic [2:0]                 wrKind = '0;
  logic [1:0]                 wrWordIdx = '0;
  logic [3:0]                 wrStrb = '0;
  logic [31:0]                wrData = '0;
  logic [NUM_SRC-1:0]         enVec, trigVec, modelVec;
  logic [PW-1:0]              pendVec;

  logic [NUM_CPU-1:0] tgtArr [NUM_SRC];
  logic [NUM_SRC-1:0] mEn, mTrig, mModel, mLvl;
  logic [PW-1:0]      mPend;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  irq_pend_tracker #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) dut_i (
    .clk(clk), .rstN(rstN), .extLines(extLines), .tgtMask(tgtMask),
    .reqCpu(reqCpu), .wrEn(wrEn), .wrKind(wrKind), .wrWordIdx(wrWordIdx),
    .wrStrb(wrStrb), .wrData(wrData), .enVec(enVec), .trigVec(trigVec),
    .modelVec(modelVec), .pendVec(pendVec)
  );

  task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk({tag, " R5 enable"},  PW'(enVec),    PW'(mEn));
    chk({tag, " R7 trigger"}, PW'(trigVec),  PW'(mTrig));
    chk({tag, " R7 model"},   PW'(modelVec), PW'(mModel));
    chk({tag, " R6 pending"}, pendVec,       mPend);
  endtask

  // Reference model: next state from requirements R2-R10.
  task automatic modelStep();
    logic [NUM_SRC-1:0] nEn, nTrig, nModel, nLvl;
    logic [PW-1:0]      nPend;
    logic [NUM_CPU-1:0] softC, selfM;
    nEn = mEn; nTrig = mTrig; nModel = mModel; nLvl = mLvl; nPend = mPend;
    selfM = NUM_CPU'(1) << reqCpu;
    case (wrData[25:24])
      2'd0: softC = wrData[16 +: NUM_CPU];
      2'd1: softC = selfM;
      2'd2: softC = ~selfM;
      default: softC = '1;
    endcase
    for (int s = 0; s < NUM_SRC; s++) begin
      logic line, hitE, bitE, hitC, clr;
      logic [NUM_CPU-1:0] tgt, setM;
      logic [1:0] cb;
      line = 1'b0;
      tgt  = selfM;
      if (s >= 32) begin
        line = extLines[s-32];
        tgt  = tgtArr[s];
      end
      hitE = wrEn && (int'(wrWordIdx) == s / 32) && wrStrb[(s % 32) / 8];
      bitE = wrData[s % 32];
      hitC = wrEn && (int'(wrWordIdx) == s / 16) && wrStrb[(s % 16) / 4];
      cb   = wrData[2 * (s % 16) +: 2];
      setM = '0;
      clr  = 1'b0;
      case (wrKind)
        3'd0: if (hitE && (bitE || s < 16)) begin
                nEn[s] = 1'b1;
                if (line && !mTrig[s]) setM |= tgt;
              end
        3'd1: if (hitE && bitE && s >= 16) nEn[s] = 1'b0;
        3'd2: if (hitE && bitE) setM |= tgt;
        3'd3: if (hitE && bitE) clr = 1'b1;
        3'd4: if (hitC) begin
                nModel[s] = cb[0];
                nTrig[s]  = cb[1] || (s < 32);
              end
        3'd5: if (wrEn && int'(wrData[9:0]) == s) setM |= softC;
        default: ;
      endcase
      if (line && !mLvl[s] && (mTrig[s] || mEn[s])) setM |= tgt;
      nLvl[s] = line;
      nPend[s*NUM_CPU +: NUM_CPU] =
        (clr ? '0 : mPend[s*NUM_CPU +: NUM_CPU]) | setM;
    end
    mEn = nEn; mTrig = nTrig; mModel = nModel; mLvl = nLvl; mPend = nPend;
  endtask

  task automatic step();
    for (int i = 0; i < NUM_EXT; i++) tgtMask[i*NUM_CPU +: NUM_CPU] = tgtArr[i+32];
    modelStep();
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doWrite(logic [2:0] k, logic [1:0] idx, logic [3:0] sb,
                         logic [31:0] d);
    wrEn = 1'b1; wrKind = k; wrWordIdx = idx; wrStrb = sb; wrData = d;
    step();
  endtask

  function automatic logic [3:0] pendOf(int s);
    return pendVec[s*NUM_CPU +: NUM_CPU];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd7151);
    for (int s = 0; s < NUM_SRC; s++) tgtArr[s] = '0;
    mEn = '0; mTrig = '0; mModel = '0; mLvl = '0; mPend = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mEn[15:0] = 16'hFFFF; mTrig[15:0] = 16'hFFFF;
    @(negedge clk);
    // R1 reset state
    chk("R1 enable",  PW'(enVec),    PW'(64'h0000_0000_0000_FFFF));
    chk("R1 trigger", PW'(trigVec),  PW'(64'h0000_0000_0000_FFFF));
    chk("R1 model",   PW'(modelVec), '0);
    chk("R1 pending", pendVec,       '0);

    // R2 edge source 40 on line 8
    tgtArr[40] = 4'b0101;
    doWrite(3'd4, 2'd2, 4'b0100, 32'h0002_0000);
    extLines[8] = 1'b1; step();
    chk("R2 edge pend", PW'(pendOf(40)), PW'(4'b0101));
    doWrite(3'd3, 2'd1, 4'b0010, 32'h0000_0100);
    step();
    chk("R2 steady high ignored", PW'(pendOf(40)), '0);
    extLines[8] = 1'b0; step();
    chk("R2 falling ignored", PW'(pendOf(40)), '0);
    checkAll("R2");

    // R3 / R4 level source 41 on line 9
    tgtArr[41] = 4'b0011;
    extLines[9] = 1'b1; step();
    chk("R3 disabled level", PW'(pendOf(41)), '0);
    doWrite(3'd0, 2'd1, 4'b0010, 32'h0000_0200);
    chk("R4 enable pends", PW'(pendOf(41)), PW'(4'b0011));
    checkAll("R4");

    // R5 low sources cannot be disabled
    doWrite(3'd0, 2'd0, 4'b1111, 32'hFFFF_FFFF);
    doWrite(3'd1, 2'd0, 4'b1111, 32'hFFFF_FFFF);
    chk("R5 low stay on", PW'(enVec[31:0]), PW'(32'h0000_FFFF));

    // R6 set-pending to requester, clear for all CPUs
    reqCpu = 2'd2;
    doWrite(3'd2, 2'd0, 4'b0100, 32'h0010_0000);
    chk("R6 set pend requester", PW'(pendOf(20)), PW'(4'b0100));
    reqCpu = 2'd0;
    doWrite(3'd2, 2'd0, 4'b0100, 32'h0010_0000);
    chk("R6 set pend second", PW'(pendOf(20)), PW'(4'b0101));
    doWrite(3'd3, 2'd0, 4'b0100, 32'h0010_0000);
    chk("R6 clear all cpus", PW'(pendOf(20)), '0);

    // R7 configuration with forced trigger
    doWrite(3'd4, 2'd1, 4'b1111, 32'h0000_0001);
    chk("R7 model bit", PW'(modelVec[31:16]), PW'(16'h0001));
    chk("R7 forced edge", PW'(trigVec[31:16]), PW'(16'hFFFF));

    // R8 software filters, requester 1, ID 3
    reqCpu = 2'd1;
    for (int f = 0; f < 4; f++) begin
      logic [3:0] exp8;
      case (f)
        0: exp8 = 4'b1010;
        1: exp8 = 4'b0010;
        2: exp8 = 4'b1101;
        default: exp8 = 4'b1111;
      endcase
      doWrite(3'd5, 2'd0, 4'b0000, (32'(f) << 24) | 32'h000A_0003);
      chk($sformatf("R8 filter %0d", f), PW'(pendOf(3)), PW'(exp8));
      doWrite(3'd3, 2'd0, 4'b0001, 32'h0000_0008);
    end
    doWrite(3'd5, 2'd0, 4'b0000, 32'h0300_0050);
    checkAll("R8 id out of range");

    // R9 rising edge and clear-pending in the same cycle
    tgtArr[42] = 4'b1000;
    doWrite(3'd4, 2'd2, 4'b0100, 32'h0020_0000);
    extLines[10] = 1'b1;
    doWrite(3'd3, 2'd1, 4'b0010, 32'h0000_0400);
    chk("R9 set wins", PW'(pendOf(42)), PW'(4'b1000));

    // R10 byte-lane gating
    doWrite(3'd0, 2'd1, 4'b0010, 32'hFFFF_FFFF);
    chk("R10 lane gate", PW'(enVec[63:32]), PW'(32'h0000_FF00));
    checkAll("R10");

    // Random phase
    for (int s = 32; s < NUM_SRC; s++) tgtArr[s] = 4'($urandom);
    for (int c = 0; c < 600; c++) begin
      if ($urandom % 4 == 0) extLines[$urandom % NUM_EXT] ^= 1'b1;
      reqCpu = 2'($urandom);
      if ($urandom % 3 != 0) begin
        logic [31:0] d;
        logic [2:0]  k;
        k = 3'($urandom % 6);
        d = $urandom;
        if (k == 3'd5) d = {6'd0, d[25:16], 6'd0, 10'($urandom % 80)};
        doWrite(k, 2'($urandom), 4'($urandom), d);
      end else begin
        step();
      end
      checkAll("RND");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule